// File: doc/BRIEF.md
# Register Map Copy Bus for Spare Thread Contexts

This block keeps spare hardware thread contexts ready to take over an alternate branch path. Each of eight contexts owns a rename map region of 32 entries, 9 bits wide. A shared 36-bit bus streams the map of each partition's primary context, four entries per cycle, in an endless loop over eight chunks. Every spare context in the same partition copies whatever chunk is on the bus. Once it has taken a full set of eight consecutive chunks from the same primary, it is flagged as synchronized.

Spare contexts also snoop every rename write made to their primary. This keeps a synchronized spare identical to its primary with no further copy. The bus can be cut into segments, so that up to four primaries each run their own copy group. An early-ready flag rises two chunk cycles before synchronization completes, because the fetch of an alternate path can begin that much ahead of its rename stage. A context that does not take part in multi-path execution is left alone by the bus.

Top module: `msb_sync_bus`

## Requirements
- R1: After reset every bit of `sync_ok` and `early_rdy` is 0, and every map entry of every context reads 0.
- R2: A write with `wr_en`=1 to a context that is not currently a spare stores `wr_data` into entry `wr_idx` of context `wr_ctx`. It is readable on `rd_data` (combinational from `rd_ctx`, `rd_idx`) after the next clock edge.
- R3: The bus moves 4 entries per cycle. Chunk k holds entries 4k to 4k+3. The chunk index runs 0 to 7 and wraps to 0. Each spare writes the current chunk of its primary into its own region.
- R4: A spare's `sync_ok` bit is 0 after 7 clock edges as a spare of an unchanged primary and 1 after 8. From then on, the spare's whole map equals the primary's map.
- R5: A spare's `early_rdy` bit becomes 1 after 6 clock edges as a spare and stays 1 while `sync_ok` is 1.
- R6: A write to a primary is applied in the same cycle to every spare of that primary, so synchronized spares keep reading the primary's values.
- R7: If a snooped write and the bus chunk hit the same spare entry in one cycle, the snooped value is the one stored.
- R8: `part_mode` sets the groups. 0 gives {0..7}. 1 gives {0..3},{4..7}. 2 gives {0,1},{2,3},{4..7}. 3 gives {0,1},{2,3},{4,5},{6,7}. A group's primary is its lowest-indexed context with both `prim_req` and `mp_en` set. Every other context of the group with `mp_en` set is a spare. A primary never shows `early_rdy` or `sync_ok`.
- R9: A context with `mp_en`=0 is never written by the bus or by snooping. Its `sync_ok` and `early_rdy` stay 0.
- R10: When the primary serving a spare changes, through `prim_req` or `part_mode`, that spare's `sync_ok` drops after the next edge and its count restarts. Spares whose primary is unchanged keep their status.
- R11: A write addressed to a context that is currently a spare is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| part_mode | input | 2 | Bus segmentation mode |
| mp_en | input | 8 | Per-context multi-path participation |
| prim_req | input | 8 | Per-context request to act as primary |
| wr_en | input | 1 | Rename map write strobe |
| wr_ctx | input | 3 | Context targeted by the write |
| wr_idx | input | 5 | Map entry targeted by the write |
| wr_data | input | 9 | Physical register number written |
| rd_ctx | input | 3 | Context selected for reading |
| rd_idx | input | 5 | Entry selected for reading |
| rd_data | output | 9 | Selected map entry |
| sync_ok | output | 8 | Per-context fully synchronized flag |
| early_rdy | output | 8 | Per-context early fetch permission |

## Verification
The assertions check on every cycle the following properties. A synchronized spare's current bus chunk matches its primary's. A snooped write wins over a colliding chunk. The chunk index wraps. `early_rdy` precedes `sync_ok`. Primaries and non-participating contexts never show readiness. The exact cycle at which readiness appears and disappears after joining or re-designation can only be shown by the bench's scenarios, as can the full map contents seen through the read port and the grouping of each segmentation mode. The same applies to same-cycle write collisions, which the bench produces at every possible chunk phase.

// File: rtl/msb_pkg.sv
`timescale 1ns/1ps
package msb_pkg;

  typedef enum logic [1:0] {
    PART_ONE   = 2'd0,
    PART_HALF  = 2'd1,
    PART_TRI   = 2'd2,
    PART_QUAD  = 2'd3
  } part_mode_e;

  // Group number of a context under a segmentation mode.
  function automatic int part_group(input int ctx, input part_mode_e mode, input int ctx_n);
    case (mode)
      PART_ONE:  return 0;
      PART_HALF: return ctx / (ctx_n / 2);
      PART_TRI:  return (ctx < ctx_n / 2) ? ctx / (ctx_n / 4) : 2;
      default:   return ctx / (ctx_n / 4);
    endcase
  endfunction

endpackage

// File: rtl/msb_part_decode.sv
`timescale 1ns/1ps
module msb_part_decode
  import msb_pkg::*;
#(
  parameter int CTX_N = 8,
  parameter int CTX_W = $clog2(CTX_N)
) (
  input  logic [1:0]                  part_mode,
  input  logic [CTX_N-1:0]            mp_en,
  input  logic [CTX_N-1:0]            prim_req,
  output logic [CTX_N-1:0]            is_prim,
  output logic [CTX_N-1:0]            is_spare,
  output logic [CTX_N-1:0][CTX_W-1:0] src_ctx
);

  logic found;

  always_comb begin
    is_prim  = '0;
    is_spare = '0;
    src_ctx  = '0;
    found    = 1'b0;
    for (int c = 0; c < CTX_N; c++) begin
      found = 1'b0;
      for (int j = 0; j < CTX_N; j++) begin
        if (!found && prim_req[j] && mp_en[j] &&
            (part_group(j, part_mode_e'(part_mode), CTX_N) ==
             part_group(c, part_mode_e'(part_mode), CTX_N))) begin
          found      = 1'b1;
          src_ctx[c] = CTX_W'(j);
        end
      end
      is_prim[c]  = found && (src_ctx[c] == CTX_W'(c));
      is_spare[c] = found && mp_en[c] && (src_ctx[c] != CTX_W'(c));
    end
  end

endmodule

// File: rtl/msb_map_region.sv
`timescale 1ns/1ps
module msb_map_region #(
  parameter int ENT_N = 32,
  parameter int ENT_W = 9,
  parameter int EPC   = 4,
  parameter int IDX_W = $clog2(ENT_N),
  parameter int CHK_W = $clog2(ENT_N / EPC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_we,
  input  logic [CHK_W-1:0]       chk_sel,
  input  logic [EPC*ENT_W-1:0]   chk_din,
  input  logic                   ent_we,
  input  logic [IDX_W-1:0]       ent_idx,
  input  logic [ENT_W-1:0]       ent_din,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [ENT_W-1:0]       rd_dout,
  output logic [EPC*ENT_W-1:0]   chk_dout
);

  logic [ENT_W-1:0] map_q [ENT_N];
  logic [ENT_W-1:0] map_d [ENT_N];
  logic             map_en;

  // Chunk copy first, then the snooped or direct write overrides it.
  always_comb begin
    map_d = map_q;
    if (chk_we) begin
      for (int k = 0; k < EPC; k++) begin
        map_d[int'(chk_sel) * EPC + k] = chk_din[k*ENT_W +: ENT_W];
      end
    end
    if (ent_we) begin
      map_d[ent_idx] = ent_din;
    end
  end

  assign map_en = chk_we | ent_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT_N; i++) map_q[i] <= '0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  always_comb begin
    for (int k = 0; k < EPC; k++) begin
      chk_dout[k*ENT_W +: ENT_W] = map_q[int'(chk_sel) * EPC + k];
    end
  end

  assign rd_dout = map_q[rd_idx];

  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && chk_we && ((int'(ent_idx) / EPC) == int'(chk_sel))) |=>
      (map_q[$past(ent_idx)] == $past(ent_din)))
    else $error("snooped write lost to bus chunk"); // R7

endmodule

// File: rtl/msb_sync_track.sv
`timescale 1ns/1ps
module msb_sync_track #(
  parameter int CHK_N = 8,
  parameter int CTX_W = 3,
  parameter int CNT_W = $clog2(CHK_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_spare,
  input  logic [CTX_W-1:0] src_ctx,
  output logic             sync_ok,
  output logic             early_rdy
);

  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(CHK_N);
  localparam logic [CNT_W-1:0] CNT_EARLY = CNT_W'(CHK_N - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CTX_W-1:0] src_q;
  logic             spare_q;
  logic             same_src;
  logic             trk_en;

  assign same_src = spare_q && (src_q == src_ctx);
  assign trk_en   = is_spare | spare_q | (cnt_q != '0);

  always_comb begin
    cnt_d = '0;
    if (is_spare) begin
      if (!same_src)             cnt_d = CNT_W'(1);
      else if (cnt_q != CNT_FULL) cnt_d = cnt_q + CNT_W'(1);
      else                       cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      src_q   <= '0;
      spare_q <= 1'b0;
    end else if (trk_en) begin
      cnt_q   <= cnt_d;
      src_q   <= src_ctx;
      spare_q <= is_spare;
    end
  end

  assign sync_ok   = (cnt_q == CNT_FULL);
  assign early_rdy = (cnt_q >= CNT_EARLY);

endmodule

// File: rtl/msb_sync_bus.sv
`timescale 1ns/1ps
module msb_sync_bus #(
  parameter int CTX_N = 8,
  parameter int ENT_N = 32,
  parameter int ENT_W = 9,
  parameter int BUS_W = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 part_mode,
  input  logic [CTX_N-1:0]           mp_en,
  input  logic [CTX_N-1:0]           prim_req,
  input  logic                       wr_en,
  input  logic [$clog2(CTX_N)-1:0]   wr_ctx,
  input  logic [$clog2(ENT_N)-1:0]   wr_idx,
  input  logic [ENT_W-1:0]           wr_data,
  input  logic [$clog2(CTX_N)-1:0]   rd_ctx,
  input  logic [$clog2(ENT_N)-1:0]   rd_idx,
  output logic [ENT_W-1:0]           rd_data,
  output logic [CTX_N-1:0]           sync_ok,
  output logic [CTX_N-1:0]           early_rdy
);

  localparam int CTX_W    = $clog2(CTX_N);
  localparam int IDX_W    = $clog2(ENT_N);
  localparam int EPC      = BUS_W / ENT_W;
  localparam int CHK_N    = ENT_N / EPC;
  localparam int CHK_W    = $clog2(CHK_N);
  localparam int CHK_BITS = EPC * ENT_W;
  localparam logic [CHK_W-1:0] CHK_LAST = CHK_W'(CHK_N - 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Free-running chunk index shared by all bus segments.
  logic [CHK_W-1:0] chk_q, chk_d;
  logic             chk_en;

  assign chk_en = 1'b1;
  always_comb begin
    chk_d = (chk_q == CHK_LAST) ? '0 : chk_q + CHK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  chk_q <= '0;
    else if (chk_en)  chk_q <= chk_d;
  end

  AST_CHK_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_q == CHK_LAST) |=> (chk_q == '0))
    else $error("chunk index did not wrap"); // R3

  logic [CTX_N-1:0]            is_prim, is_spare;
  logic [CTX_N-1:0][CTX_W-1:0] src_ctx;

  msb_part_decode #(.CTX_N(CTX_N), .CTX_W(CTX_W)) u_decode (
    .part_mode (part_mode),
    .mp_en     (mp_en),
    .prim_req  (prim_req),
    .is_prim   (is_prim),
    .is_spare  (is_spare),
    .src_ctx   (src_ctx)
  );

  logic [CTX_N-1:0]               ent_we;
  logic [CTX_N-1:0][CHK_BITS-1:0] chk_dout;
  logic [CTX_N-1:0][CHK_BITS-1:0] chk_din;
  logic [CTX_N-1:0][ENT_W-1:0]    rd_dout;

  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    // Segment bus: a spare listens to the chunk its own primary drives.
    assign chk_din[c] = chk_dout[src_ctx[c]];

    // Spares take only snooped writes of their primary; others take direct writes.
    assign ent_we[c] = wr_en && (is_spare[c] ? (src_ctx[c] == wr_ctx)
                                             : (wr_ctx == CTX_W'(c)));

    msb_map_region #(
      .ENT_N (ENT_N), .ENT_W (ENT_W), .EPC (EPC), .IDX_W (IDX_W), .CHK_W (CHK_W)
    ) u_region (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .chk_we   (is_spare[c]),
      .chk_sel  (chk_q),
      .chk_din  (chk_din[c]),
      .ent_we   (ent_we[c]),
      .ent_idx  (wr_idx),
      .ent_din  (wr_data),
      .rd_idx   (rd_idx),
      .rd_dout  (rd_dout[c]),
      .chk_dout (chk_dout[c])
    );

    msb_sync_track #(.CHK_N (CHK_N), .CTX_W (CTX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .is_spare  (is_spare[c]),
      .src_ctx   (src_ctx[c]),
      .sync_ok   (sync_ok[c]),
      .early_rdy (early_rdy[c])
    );

    AST_SPARE_MIRROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sync_ok[c] && $stable(src_ctx[c]) && $stable(is_spare[c])) |->
        (chk_dout[c] == chk_dout[src_ctx[c]]))
      else $error("synchronized spare differs from primary"); // R6

    AST_EARLY_LEADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(sync_ok[c]) |-> $past(early_rdy[c]))
      else $error("sync without prior early ready"); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!mp_en[c] && !$past(mp_en[c])) |-> (!early_rdy[c] && !sync_ok[c]))
      else $error("non-participating context shows readiness"); // R9

    AST_PRIM_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (is_prim[c] && $past(is_prim[c])) |-> (!early_rdy[c] && !sync_ok[c]))
      else $error("primary context shows readiness"); // R8
  end

  assign rd_data = rd_dout[rd_ctx];

endmodule

// File: tb/msb_sync_bus_bench.sv
`timescale 1ns/1ps
module msb_sync_bus_bench;

  localparam int CTX_N = 8;
  localparam int ENT_N = 32;
  localparam int ENT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       part_mode;
  logic [CTX_N-1:0] mp_en, prim_req;
  logic             wr_en;
  logic [2:0]       wr_ctx, rd_ctx;
  logic [4:0]       wr_idx, rd_idx;
  logic [ENT_W-1:0] wr_data, rd_data;
  logic [CTX_N-1:0] sync_ok, early_rdy;

  always #10 clk = ~clk;

  msb_sync_bus u_msb_sync_bus (
    .clk (clk), .rst_n (rst_n), .part_mode (part_mode), .mp_en (mp_en),
    .prim_req (prim_req), .wr_en (wr_en), .wr_ctx (wr_ctx), .wr_idx (wr_idx),
    .wr_data (wr_data), .rd_ctx (rd_ctx), .rd_idx (rd_idx), .rd_data (rd_data),
    .sync_ok (sync_ok), .early_rdy (early_rdy)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int mdl [CTX_N][ENT_N];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int ctx, input int idx, output int val);
    rd_ctx = 3'(ctx);
    rd_idx = 5'(idx);
    #1;
    val = int'(rd_data);
  endtask

  // Compare a whole region with a model region; reads span edges only while idle.
  task automatic chk_map(input string req, input int ctx, input int exp_ctx);
    int v;
    for (int i = 0; i < ENT_N; i++) begin
      rd(ctx, i, v);
      chk(req, v, mdl[exp_ctx][i]);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit targets_spare(input int ctx, input int mode, input logic [7:0] pr,
                                       input logic [7:0] mp);
    int gc, gj;
    bit f;
    f = 0;
    for (int j = 0; j < CTX_N; j++) begin
      case (mode)
        0: begin gc = 0; gj = 0; end
        1: begin gc = ctx / 4; gj = j / 4; end
        2: begin gc = (ctx < 4) ? ctx / 2 : 2; gj = (j < 4) ? j / 2 : 2; end
        default: begin gc = ctx / 2; gj = j / 2; end
      endcase
      if (!f && gc == gj && pr[j] && mp[j]) begin
        f = 1;
        if (j == ctx) return 0;
      end
    end
    return f && mp[ctx];
  endfunction

  // One write per cycle; the model follows the block's write rule (R2, R11).
  task automatic do_wr(input int ctx, input int idx, input int data);
    wr_en   = 1'b1;
    wr_ctx  = 3'(ctx);
    wr_idx  = 5'(idx);
    wr_data = 9'(data);
    if (!targets_spare(ctx, int'(part_mode), prim_req, mp_en)) mdl[ctx][idx] = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; part_mode = 2'd0; mp_en = '0; prim_req = '0;
    wr_en = 1'b0; wr_ctx = '0; wr_idx = '0; wr_data = '0; rd_ctx = '0; rd_idx = '0;
    for (int c = 0; c < CTX_N; c++) for (int i = 0; i < ENT_N; i++) mdl[c][i] = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1: reset state
    chk("R1 sync_ok", int'(sync_ok), 0);
    chk("R1 early_rdy", int'(early_rdy), 0);
    rd(0, 0, v);  chk("R1 entry 0/0", v, 0);
    rd(7, 31, v); chk("R1 entry 7/31", v, 0);
    wait_n(1);

    // R2: direct writes with nothing participating
    for (int i = 0; i < ENT_N; i++) do_wr(0, i, int'($urandom % 512));
    for (int i = 0; i < ENT_N; i++) do_wr(7, i, int'($urandom % 512));
    chk_map("R2 ctx0", 0, 0);
    chk_map("R2 ctx7", 7, 7);
    wait_n(1);

    // R4 R5 R9: one group, primary 0, ctx7 not participating
    mp_en = 8'h7F; prim_req = 8'h01;
    wait_n(5);
    chk("R5 early after 5", int'(early_rdy), 8'h00);
    wait_n(1);
    chk("R5 early after 6", int'(early_rdy), 8'h7E);
    chk("R4 sync after 6", int'(sync_ok), 8'h00);
    wait_n(1);
    chk("R4 sync after 7", int'(sync_ok), 8'h00);
    wait_n(1);
    chk("R4 sync after 8", int'(sync_ok), 8'h7E);
    chk("R5 early with sync", int'(early_rdy), 8'h7E);
    chk_map("R3 ctx3 copy of ctx0", 3, 0);
    chk_map("R9 ctx7 untouched", 7, 7);
    wait_n(1);

    // R6 R11 R9: random writes to primary, to ctx7, and to a spare
    for (int n = 0; n < 80; n++) begin
      int sel;
      sel = int'($urandom % 4);
      if (sel == 0)      do_wr(7, int'($urandom % 32), int'($urandom % 512));
      else if (sel == 1) do_wr(2, int'($urandom % 32), int'($urandom % 512));
      else               do_wr(0, int'($urandom % 32), int'($urandom % 512));
    end
    chk("R6 sync held", int'(sync_ok), 8'h7E);
    for (int c = 1; c < 7; c++) chk_map("R6 spare mirrors ctx0", c, 0);
    chk_map("R11 spare ctx2 ignored direct writes", 2, 0);
    chk_map("R9 ctx7 direct writes only", 7, 7);
    wait_n(1);

    // R7: every chunk phase, writes landing on the chunk currently on the bus
    for (int d = 0; d < 8; d++) begin
      int ent [8];
      for (int i = 0; i < 8; i++) begin
        ent[i] = ((i + d) % 8) * 4 + (d % 4);
        do_wr(0, ent[i], (mdl[0][ent[i]] ^ ((i + 1) * 37 + d)) & 511);
      end
      for (int i = 0; i < 8; i++) begin
        rd(4, ent[i], v);
        chk("R7 snoop beats chunk", v, mdl[0][ent[i]]);
      end
      wait_n(1);
    end

    // R8 R10: four groups, primaries 0,2,4,6
    for (int i = 0; i < ENT_N; i++) begin
      mdl[2][i] = mdl[0][i]; mdl[4][i] = mdl[0][i]; mdl[6][i] = mdl[0][i];
    end
    part_mode = 2'd3; mp_en = 8'hFF; prim_req = 8'h55;
    wait_n(1);
    chk("R10 regroup keeps ctx1 only", int'(sync_ok), 8'h02);
    for (int n = 0; n < 20; n++) do_wr(2 * int'($urandom % 4), int'($urandom % 32),
                                       int'($urandom % 512));
    wait_n(8);
    chk("R8 quad sync", int'(sync_ok), 8'hAA);
    chk_map("R8 ctx1 from ctx0", 1, 0);
    chk_map("R8 ctx3 from ctx2", 3, 2);
    chk_map("R8 ctx5 from ctx4", 5, 4);
    chk_map("R8 ctx7 from ctx6", 7, 6);
    wait_n(1);

    // R10: primary of {2,3} moves to 3; R8: 4 beats 5 in {4,5}
    for (int i = 0; i < ENT_N; i++) mdl[3][i] = mdl[2][i];
    prim_req = 8'h79;
    wait_n(1);
    chk("R10 redesignate clears ctx2", int'(sync_ok), 8'hA2);
    wait_n(6);
    chk("R4 ctx2 not yet synced", int'(sync_ok), 8'hA2);
    chk("R5 ctx2 early", int'(early_rdy), 8'hA6);
    wait_n(1);
    chk("R10 ctx2 synced again", int'(sync_ok), 8'hA6);
    for (int n = 0; n < 12; n++) do_wr(3, int'($urandom % 32), int'($urandom % 512));
    for (int n = 0; n < 6; n++)  do_wr(5, int'($urandom % 32), int'($urandom % 512));
    chk_map("R6 ctx2 mirrors ctx3", 2, 3);
    chk_map("R11 ctx5 ignored writes", 5, 4);
    wait_n(1);

    // R8: mode 2, group {4..7} served by 4
    part_mode = 2'd2;
    wait_n(1);
    chk("R10 mode2 regroup", int'(sync_ok), 8'h26);
    wait_n(7);
    chk("R8 mode2 sync", int'(sync_ok), 8'hE6);
    chk_map("R8 ctx6 from ctx4", 6, 4);
    chk_map("R8 ctx7 from ctx4", 7, 4);
    wait_n(1);

    // R6 R11: random writes to any context in mode 2
    for (int n = 0; n < 150; n++) do_wr(int'($urandom % 8), int'($urandom % 32),
                                        int'($urandom % 512));
    chk("R6 mode2 sync held", int'(sync_ok), 8'hE6);
    chk_map("R6 ctx1 vs ctx0", 1, 0);
    chk_map("R6 ctx2 vs ctx3", 2, 3);
    chk_map("R6 ctx5 vs ctx4", 5, 4);
    chk_map("R6 ctx6 vs ctx4", 6, 4);
    chk_map("R6 ctx7 vs ctx4", 7, 4);
    chk_map("R2 ctx0 model", 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule